// File: doc/BRIEF.md
# Shared-Register Multi-Line Serial Transmitter

This block drives several asynchronous serial lines from a single register interface. Software does not get a separate holding register for each line. A scanner walks over the lines that software has enabled and stops at the first one whose one-character holding buffer is empty. It then raises a ready flag and reports that line's number in the control/status register. The next character written to the shared data register goes to that line, and the scanner moves on.

Each line serialises its character as one low start bit, eight data bits (least significant first) and one high stop bit. Every bit lasts `TICK_DIV` clock cycles, and one tick source is shared by all lines. A line can hold one character in its buffer while it shifts another out. An interrupt output tells software that the scanner is waiting for data. A clear bit re-initialises the whole block.

The register bus has no back-pressure. A write completes in the cycle it is presented, and reads return data combinationally. Flow control is the ready flag alone: a character written while the flag is low is dropped.

Top module: `txs_mux_tx`

## Requirements
- R1: After reset every readable field is zero. Register 0 (control/status) and register 1 (line enables) read 0, all serial outputs are high and the interrupt is low.
- R2: Register 0 holds the ready flag in bit 15 and the line number in bits 9:8. While scanning, the scanner stops on the first enabled line with an empty buffer and raises the ready flag with that line's number. With no line enabled, the flag stays low.
- R3: A write to register 2 while the ready flag is set loads bits 7:0 into the indicated line's buffer and drops the flag. The scanner then resumes at the next line number in round-robin order, so with all four lines enabled and idle they are offered as 0, 1, 2, 3.
- R4: Each line sends an idle-high frame: a low start bit, eight data bits LSB first, then a high stop bit, each lasting `TICK_DIV` cycles.
- R5: A line buffers one character while it shifts another. The ready flag is not raised for that line again until its buffered character has moved into the shifter.
- R6: Clearing the enable bit (register 1, bit n for line n) of the line the scanner is stopped on drops the ready flag. The scanner then advances to another enabled line.
- R7: The interrupt is high exactly when the ready flag and the interrupt enable bit (register 0, bit 2) are both set.
- R8: Writing 1 to register 0 bit 0 starts a clear. That bit reads 1 for `CLR_CYCLES` cycles after the write and then reads 0. Afterwards all registers are zero and all lines are idle.
- R9: The scanner runs only while register 0 bit 1 (scan enable) is set. With it clear, the ready flag stays low.
- R10: A write to register 2 while the ready flag is low is ignored: no line transmits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 line enables, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| txd | output | NUM_LINES | Serial outputs, bit n is line n, idle high |
| irq | output | 1 | Transmit-ready interrupt |

## Verification
The bench targets the hand-off between the scanner and each line's single buffer. If a design re-offered a line before its buffered character reached the shifter, it would overwrite that character. If it failed to advance after a write, it would keep offering the same line instead of rotating 0 to 3. The bench withdraws the enable of the line the scanner is stopped on, which would leave a wrong design stuck with the flag up. It writes data while the flag is low, which a wrong design would transmit. It also checks the exact length of the clear pulse and decodes every frame on the serial pins to catch wrong bit order or wrong bit timing.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR    = 2'd0,
    REG_TXEN   = 2'd1,
    REG_TXDATA = 2'd2
  } reg_addr_e;

  // control/status bit positions
  localparam int CSR_CLR_BIT   = 0;
  localparam int CSR_SCAN_BIT  = 1;
  localparam int CSR_TIE_BIT   = 2;
  localparam int CSR_LINE_LSB  = 8;
  localparam int CSR_READY_BIT = 15;
endpackage

// File: rtl/txs_bit_tick.sv
module txs_bit_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (srst)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txs_line.sv
module txs_line #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              tick,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  output logic              hold_full,
  output logic              txd
);
  localparam int FRAME_W = CHAR_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [CHAR_W-1:0]  hold_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   bit_q;
  logic               busy_q;
  logic               last_bit;
  logic               take_hold;

  assign last_bit  = (bit_q == CNT_W'(FRAME_W - 1));
  assign take_hold = tick && (!busy_q || last_bit) && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      bit_q   <= '0;
      busy_q  <= 1'b0;
    end else if (srst) begin
      shreg_q <= '1;
      bit_q   <= '0;
      busy_q  <= 1'b0;
    end else if (tick) begin
      if (busy_q && !last_bit) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        bit_q   <= bit_q + 1'b1;
      end else if (hold_full) begin
        shreg_q <= {1'b1, hold_q, 1'b0};
        bit_q   <= '0;
        busy_q  <= 1'b1;
      end else begin
        busy_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (srst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (load) begin
      hold_q    <= load_data;
      hold_full <= 1'b1;
    end else if (take_hold) begin
      hold_full <= 1'b0;
    end
  end

  assign txd = busy_q ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/txs_scanner.sv
module txs_scanner #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 srst,
  input  logic                 scan_en,
  input  logic [N-1:0]         line_en,
  input  logic [N-1:0]         hold_empty,
  input  logic                 take,
  output logic                 ready,
  output logic [$clog2(N)-1:0] line
);
  localparam int LW = $clog2(N);

  logic [LW-1:0] ptr_q;
  logic [LW-1:0] ptr_next;
  logic          parked_q;

  assign ptr_next = (ptr_q == LW'(N - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      parked_q <= 1'b0;
    end else if (srst) begin
      ptr_q    <= '0;
      parked_q <= 1'b0;
    end else if (!scan_en) begin
      parked_q <= 1'b0;
    end else if (parked_q) begin
      if (take || !line_en[ptr_q]) begin
        parked_q <= 1'b0;
        ptr_q    <= ptr_next;
      end
    end else if (line_en[ptr_q] && hold_empty[ptr_q]) begin
      parked_q <= 1'b1;
    end else begin
      ptr_q <= ptr_next;
    end
  end

  assign ready = parked_q;
  assign line  = ptr_q;
endmodule

// File: rtl/txs_mux_tx.sv
module txs_mux_tx
  import txs_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int CHAR_W     = 8,
  parameter int TICK_DIV   = 4,
  parameter int CLR_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] txd,
  output logic                 irq
);
  localparam int LW    = $clog2(NUM_LINES);
  localparam int CLR_W = $clog2(CLR_CYCLES + 1);

  logic                 scan_en;
  logic                 tie_q;
  logic [NUM_LINES-1:0] txen_q;
  logic [CLR_W-1:0]     clr_cnt_q;
  logic                 clr_busy;
  logic                 tick;
  logic                 ready;
  logic [LW-1:0]        line;
  logic [NUM_LINES-1:0] hold_full;
  logic                 data_wr;
  logic                 take;

  assign clr_busy = (clr_cnt_q != '0);
  assign data_wr  = bus_wr && (bus_addr == REG_TXDATA);
  assign take     = data_wr && ready && !clr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_en   <= 1'b0;
      tie_q     <= 1'b0;
      txen_q    <= '0;
      clr_cnt_q <= '0;
    end else if (clr_busy) begin
      scan_en   <= 1'b0;
      tie_q     <= 1'b0;
      txen_q    <= '0;
      clr_cnt_q <= clr_cnt_q - 1'b1;
    end else if (bus_wr) begin
      if (bus_addr == REG_CSR) begin
        if (bus_wdata[CSR_CLR_BIT]) begin
          clr_cnt_q <= CLR_W'(CLR_CYCLES);
        end else begin
          scan_en <= bus_wdata[CSR_SCAN_BIT];
          tie_q   <= bus_wdata[CSR_TIE_BIT];
        end
      end else if (bus_addr == REG_TXEN) begin
        txen_q <= bus_wdata[NUM_LINES-1:0];
      end
    end
  end

  txs_bit_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .srst  (clr_busy),
    .tick  (tick)
  );

  txs_scanner #(.N(NUM_LINES)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (clr_busy),
    .scan_en    (scan_en),
    .line_en    (txen_q),
    .hold_empty (~hold_full),
    .take       (take),
    .ready      (ready),
    .line       (line)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    txs_line #(.CHAR_W(CHAR_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (clr_busy),
      .tick      (tick),
      .load      (take && (line == LW'(i))),
      .load_data (bus_wdata[CHAR_W-1:0]),
      .hold_full (hold_full[i]),
      .txd       (txd[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CSR: begin
        bus_rdata[CSR_CLR_BIT]              = clr_busy;
        bus_rdata[CSR_SCAN_BIT]             = scan_en;
        bus_rdata[CSR_TIE_BIT]              = tie_q;
        bus_rdata[CSR_LINE_LSB +: LW]       = ready ? line : '0;
        bus_rdata[CSR_READY_BIT]            = ready;
      end
      REG_TXEN: bus_rdata[NUM_LINES-1:0]    = txen_q;
      default:  bus_rdata                   = '0;
    endcase
  end

  assign irq = ready && tie_q;
endmodule

// File: rtl/txs_mux_tx_chk.sv
module txs_mux_tx_chk #(
  parameter int N = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ready,
  input logic [$clog2(N)-1:0] line,
  input logic [N-1:0]         hold_full,
  input logic                 take,
  input logic                 data_wr,
  input logic                 scan_en,
  input logic                 irq,
  input logic                 clr_busy,
  input logic [N-1:0]         txd
);
  // R2
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !hold_full[line]);

  // R3
  take_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> hold_full[$past(line)]);

  // R10
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ready) |=> ($countones(hold_full) <= $past($countones(hold_full))));

  // R9
  irq_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scan_en);

  // R8
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && $past(clr_busy)) |-> ((&txd) && (hold_full == '0) && !ready));
endmodule

bind txs_mux_tx txs_mux_tx_chk #(.N(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .line      (line),
  .hold_full (hold_full),
  .take      (take),
  .data_wr   (data_wr),
  .scan_en   (scan_en),
  .irq       (irq),
  .clr_busy  (clr_busy),
  .txd       (txd)
);

// File: tb/sim_txs_mux_tx.sv
module sim_txs_mux_tx;
  localparam int NL   = 4;
  localparam int TDIV = 4;
  localparam int CLRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NL-1:0] txd;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txs_mux_tx #(.NUM_LINES(NL), .CHAR_W(8), .TICK_DIV(TDIV), .CLR_CYCLES(CLRC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .irq(irq)
  );

  // serial frame decoders, one per line
  for (genvar g = 0; g < NL; g++) begin : g_mon
    int         rx_cnt = 0;
    int         ferr = 0;
    logic [7:0] rx_byte = '0;
    initial begin
      forever begin
        @(negedge clk);
        if (rst_n && txd[g] === 1'b0) begin
          logic [7:0] b;
          repeat (TDIV/2 - 1) @(negedge clk);
          if (txd[g] !== 1'b0) ferr++;
          for (int k = 0; k < 8; k++) begin
            repeat (TDIV) @(negedge clk);
            b[k] = txd[g];
          end
          repeat (TDIV) @(negedge clk);
          if (txd[g] !== 1'b1) ferr++;
          rx_byte = b;
          rx_cnt++;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_ready(output int rdy, output int ln);
    logic [15:0] v;
    rd_reg(2'd0, v);
    rdy = int'(v[15]);
    ln  = int'(v[9:8]);
  endtask

  // R8: clear pulse length and cleared state
  task automatic do_clear();
    logic [15:0] v;
    int busy_reads = 0;
    wr_reg(2'd0, 16'h0001);
    for (int i = 0; i < 20; i++) begin
      rd_reg(2'd0, v);
      if (!v[0]) break;
      busy_reads++;
    end
    // busy for CLR_CYCLES cycles after the write edge: reads at +1.5 .. +3.5
    check("R8 clear busy length", busy_reads, CLRC - 1);
    check("R8 csr after clear", int'(v), 0);
    rd_reg(2'd1, v);
    check("R8 enables after clear", int'(v), 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(2'd0, v);
    check("R1 csr", int'(v), 0);
    rd_reg(2'd1, v);
    check("R1 enables", int'(v), 0);
    check("R1 txd idle", int'(txd), 4'hF);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr_reg(2'd1, 16'h000F);
    wr_reg(2'd0, 16'h0006);
    idle(3);
    rd_reg(2'd0, v);
    check("R8 ready before clear", int'(v[15]), 1);
    do_clear();
    check("R8 irq after clear", int'(irq), 0);
    check("R8 lines idle", int'(txd), 4'hF);
  endtask

  task automatic t_scan_off();
    int rdy, ln;
    do_clear();
    wr_reg(2'd1, 16'h000F);
    wr_reg(2'd0, 16'h0004);
    idle(10);
    rd_ready(rdy, ln);
    check("R9 no ready while scan off", rdy, 0);
    check("R9 no irq while scan off", int'(irq), 0);
    wr_reg(2'd0, 16'h0006);
    idle(3);
    rd_ready(rdy, ln);
    check("R9 ready once scan on", rdy, 1);
  endtask

  task automatic t_single_park();
    int rdy, ln;
    do_clear();
    wr_reg(2'd0, 16'h0002);
    idle(10);
    rd_ready(rdy, ln);
    check("R2 no line enabled", rdy, 0);
    wr_reg(2'd1, 16'h0004);
    idle(6);
    rd_ready(rdy, ln);
    check("R2 ready on line 2", rdy, 1);
    check("R2 line field", ln, 2);
  endtask

  task automatic t_round_robin();
    int rdy, ln;
    int base0, base1, base2, base3;
    base0 = g_mon[0].rx_cnt; base1 = g_mon[1].rx_cnt;
    base2 = g_mon[2].rx_cnt; base3 = g_mon[3].rx_cnt;
    do_clear();
    wr_reg(2'd1, 16'h000F);
    wr_reg(2'd0, 16'h0002);
    idle(3);
    for (int i = 0; i < 4; i++) begin
      rd_ready(rdy, ln);
      check("R3 ready in rotation", rdy, 1);
      check("R3 rotation order", ln, i);
      wr_reg(2'd2, 16'(8'h11 * (i + 1)));
      idle(1);
    end
    idle(80);
    check("R4 line0 count", g_mon[0].rx_cnt - base0, 1);
    check("R4 line1 count", g_mon[1].rx_cnt - base1, 1);
    check("R4 line2 count", g_mon[2].rx_cnt - base2, 1);
    check("R4 line3 count", g_mon[3].rx_cnt - base3, 1);
    check("R4 line0 byte", int'(g_mon[0].rx_byte), 8'h11);
    check("R4 line1 byte", int'(g_mon[1].rx_byte), 8'h22);
    check("R4 line2 byte", int'(g_mon[2].rx_byte), 8'h33);
    check("R4 line3 byte", int'(g_mon[3].rx_byte), 8'h44);
  endtask

  task automatic t_one_buffer();
    int rdy, ln, base, n;
    base = g_mon[0].rx_cnt;
    do_clear();
    wr_reg(2'd1, 16'h0001);
    wr_reg(2'd0, 16'h0002);
    idle(3);
    wr_reg(2'd2, 16'h00C3);
    rdy = 0;
    for (n = 0; n < 12 && rdy == 0; n++) rd_ready(rdy, ln);
    check("R5 ready again after move to shifter", rdy, 1);
    wr_reg(2'd2, 16'h003C);
    idle(10);
    rd_ready(rdy, ln);
    check("R5 no ready while buffer full", rdy, 0);
    rdy = 0;
    for (n = 0; n < 60 && rdy == 0; n++) rd_ready(rdy, ln);
    check("R5 ready after second char taken", rdy, 1);
    idle(60);
    check("R5 two frames sent", g_mon[0].rx_cnt - base, 2);
    check("R4 last byte", int'(g_mon[0].rx_byte), 8'h3C);
  endtask

  task automatic t_enable_drop();
    int rdy, ln;
    do_clear();
    wr_reg(2'd1, 16'h000A);
    wr_reg(2'd0, 16'h0002);
    idle(4);
    rd_ready(rdy, ln);
    check("R6 parked line", ln, 1);
    wr_reg(2'd1, 16'h0008);
    rd_ready(rdy, ln);
    check("R6 ready drops", rdy, 0);
    idle(4);
    rd_ready(rdy, ln);
    check("R6 moves to other line ready", rdy, 1);
    check("R6 moves to other line", ln, 3);
  endtask

  task automatic t_irq();
    int rdy, ln;
    do_clear();
    wr_reg(2'd1, 16'h0001);
    wr_reg(2'd0, 16'h0002);
    idle(3);
    rd_ready(rdy, ln);
    check("R7 ready set", rdy, 1);
    check("R7 irq off without enable", int'(irq), 0);
    wr_reg(2'd0, 16'h0006);
    check("R7 irq on", int'(irq), 1);
    wr_reg(2'd2, 16'h0081);
    check("R7 irq drops with ready", int'(irq), 0);
    idle(60);
  endtask

  task automatic t_ignored_write();
    int rdy, ln, base;
    base = g_mon[0].rx_cnt;
    do_clear();
    wr_reg(2'd1, 16'h0001);
    wr_reg(2'd2, 16'h005A);
    idle(60);
    check("R10 nothing sent", g_mon[0].rx_cnt - base, 0);
    check("R10 line idle", int'(txd[0]), 1);
    wr_reg(2'd0, 16'h0002);
    idle(3);
    rd_ready(rdy, ln);
    check("R10 buffer still empty", rdy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_clear();
    t_scan_off();
    t_single_park();
    t_round_robin();
    t_one_buffer();
    t_enable_drop();
    t_irq();
    t_ignored_write();
    check("R4 no framing errors",
          g_mon[0].ferr + g_mon[1].ferr + g_mon[2].ferr + g_mon[3].ferr, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule